// File: doc/BRIEF.md
# Streaming GRU Recurrent Cell

This block evaluates one layer of a gated recurrent unit over a sequence of feature vectors. Each timestep it collects one input vector, element by element, from a valid/ready stream into a local buffer. It then accumulates two separate sets of gate pre-activations. One set comes from the input vector and the input-path weights. The other comes from the previous hidden state and the hidden-path weights. Each set gets its own bias. A short pipeline then turns these terms into the reset gate, the update gate, the candidate and the new hidden value, one hidden element per cycle. The new hidden vector is streamed out, one element per beat, before the next timestep's input is accepted.

All values are signed 16-bit fixed point with 12 fraction bits (one is 4096). Products accumulate at 48 bits and are rounded and saturated back to 16 bits. Weights and biases are loaded beforehand through a write port. The weight memories are split into lanes so that several gate columns are multiplied per cycle. A one-cycle start pulse clears the hidden state and begins a new sequence whose length is a parameter.

Top module: `gru_cell`

## Requirements
- R1: A write with `cfg_sel` 0 stores the input-path weight W_x[row][col], 1 stores the hidden-path weight W_h[row][col], 2 stores the input bias b_x[col], 3 stores the hidden bias b_h[col]. `row` is the input-element (or hidden-element) index. Columns 0..H-1 feed the reset gate, H..2H-1 the update gate, 2H..3H-1 the candidate.
- R2: Data are signed Q4.12. `in_ready` is high only while the block collects the IN_DIM elements of a timestep's input, and never while `out_valid` is high. After reset both are low.
- R3: For each column g, the input term is p_x[g] = sat(floor((Σ_j W_x[j][g]·x_j + b_x[g]·4096 + 2048)/4096)). The hidden term p_h[g] is formed the same way from the previous hidden state and b_h. sat clamps to [-32768, 32767].
- R4: The reset gate is r = σ(sat(p_x[i]+p_h[i])) and the update gate is z = σ(sat(p_x[H+i]+p_h[H+i])), where σ(v) = clamp(floor(v/4)+2048, 0, 4096).
- R5: The candidate is n = τ(sat(floor((r·p_h[2H+i]+2048)/4096) + p_x[2H+i])), where τ(v) = clamp(v, -4096, 4096). The reset gate scales only the hidden-path candidate term.
- R6: The new hidden element is h' = sat(n + floor(((h-n)·z+2048)/4096)), with h the previous hidden value.
- R7: After each timestep the block emits H beats carrying h'[0..H-1] in order. `out_last` is high only on the final beat of timestep SEQ_LEN-1. After that beat the block idles with `in_ready` and `out_valid` low until the next `seq_start`.
- R8: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold their values.
- R9: `seq_start` zeroes the hidden state and the timestep count and abandons any timestep in progress. The next input beat becomes element 0 of timestep 0.
- R10: Saturation applies at every rounding point. Large weights and inputs drive outputs to the clamped limits, never to wrapped values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seq_start | input | 1 | Start pulse: clear hidden state, begin a sequence |
| cfg_we | input | 1 | Parameter write strobe |
| cfg_sel | input | 2 | Write target: 0 W_x, 1 W_h, 2 b_x, 3 b_h |
| cfg_row | input | RW | Row (element index) of a weight write |
| cfg_col | input | CW | Gate column of the write |
| cfg_data | input | 16 | Q4.12 value to store |
| in_valid | input | 1 | Input element valid |
| in_ready | output | 1 | Input element accepted this cycle when valid |
| in_data | input | 16 | Input element, Q4.12 |
| out_valid | output | 1 | Hidden element valid |
| out_ready | input | 1 | Consumer accepts hidden element |
| out_data | output | 16 | Hidden element, Q4.12 |
| out_last | output | 1 | Final beat of the final timestep |

## Verification
The bench sweeps several weight and input patterns through full sequences and compares every hidden beat with a bit-exact arithmetic model. A design that swapped the gate column blocks, mixed the two bias vectors, or applied the reset gate to the whole candidate sum would miss on nearly every beat. One pattern uses large weights so that the accumulations, the gate sums and the hidden update all clamp. A design that truncated instead of saturating would then produce values with the wrong sign. Output backpressure and input gaps check that held beats stay unchanged and that no element is lost or repeated. A start pulse in the middle of a vector, with prior hidden state left over, exposes a design that kept stale state or a partly filled input buffer.

// File: rtl/gru_pkg.sv
package gru_pkg;
  localparam int DW = 16;
  localparam int FB = 12;
  localparam int AW = 48;

  typedef logic signed [DW-1:0] fx_t;
  typedef logic signed [AW-1:0] acc_t;

  localparam logic [1:0] SEL_WX = 2'd0;
  localparam logic [1:0] SEL_WH = 2'd1;
  localparam logic [1:0] SEL_BX = 2'd2;
  localparam logic [1:0] SEL_BH = 2'd3;

  function automatic fx_t sat_fx(input acc_t v);
    acc_t hi;
    acc_t lo;
    hi = (acc_t'(1) <<< (DW-1)) - acc_t'(1);
    lo = -(acc_t'(1) <<< (DW-1));
    if (v > hi) return fx_t'(hi);
    if (v < lo) return fx_t'(lo);
    return fx_t'(v);
  endfunction

  function automatic acc_t rnd_sh(input acc_t v);
    return (v + (acc_t'(1) <<< (FB-1))) >>> FB;
  endfunction

  function automatic fx_t fold_bias(input acc_t a, input fx_t b);
    acc_t be;
    be = acc_t'(b);
    return sat_fx(rnd_sh(a + (be <<< FB)));
  endfunction

  function automatic acc_t mul_rnd(input fx_t a, input fx_t b);
    return rnd_sh(acc_t'(a) * acc_t'(b));
  endfunction

  function automatic fx_t hsig(input fx_t x);
    acc_t t;
    t = (acc_t'(x) >>> 2) + (acc_t'(1) <<< (FB-1));
    if (t < 0) return '0;
    if (t > (acc_t'(1) <<< FB)) return fx_t'(acc_t'(1) <<< FB);
    return fx_t'(t);
  endfunction

  function automatic fx_t htanh(input fx_t x);
    acc_t t;
    t = acc_t'(x);
    if (t > (acc_t'(1) <<< FB)) return fx_t'(acc_t'(1) <<< FB);
    if (t < -(acc_t'(1) <<< FB)) return fx_t'(-(acc_t'(1) <<< FB));
    return x;
  endfunction
endpackage

// File: rtl/gru_wbank.sv
module gru_wbank #(
  parameter int DEPTH = 8,
  parameter int DW    = 16,
  localparam int ABW  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic           clk,
  input  logic           we,
  input  logic [ABW-1:0] waddr,
  input  logic [DW-1:0]  wdata,
  input  logic [ABW-1:0] raddr,
  output logic [DW-1:0]  rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/gru_wstore.sv
module gru_wstore #(
  parameter int ROWS  = 4,
  parameter int COLS  = 12,
  parameter int LANES = 2,
  parameter int DW    = 16,
  parameter int RW    = 2,
  parameter int CW    = 4,
  parameter int CGW   = 3
) (
  input  logic                       clk,
  input  logic                       we,
  input  logic [RW-1:0]              wrow,
  input  logic [CW-1:0]              wcol,
  input  logic [DW-1:0]              wdata,
  input  logic [RW-1:0]              rrow,
  input  logic [CGW-1:0]             rcg,
  output logic [LANES-1:0][DW-1:0]   rdata
);
  localparam int CPL   = COLS / LANES;
  localparam int DEPTH = ROWS * CPL;
  localparam int ABW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [ABW-1:0] waddr;
  logic [ABW-1:0] raddr;
  int             wlane;

  always_comb begin
    wlane = int'(wcol) % LANES;
    waddr = ABW'(int'(wrow) * CPL + int'(wcol) / LANES);
    raddr = ABW'(int'(rrow) * CPL + int'(rcg));
  end

  for (genvar l = 0; l < LANES; l++) begin : g_bank
    gru_wbank #(.DEPTH(DEPTH), .DW(DW)) u_bank (
      .clk   (clk),
      .we    (we && (wlane == l)),
      .waddr (waddr),
      .wdata (wdata),
      .raddr (raddr),
      .rdata (rdata[l])
    );
  end
endmodule

// File: rtl/gru_gate_pipe.sv
module gru_gate_pipe
  import gru_pkg::*;
#(
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_vld,
  input  logic [IW-1:0] in_idx,
  input  acc_t          ax_r,
  input  acc_t          ax_z,
  input  acc_t          ax_n,
  input  acc_t          ah_r,
  input  acc_t          ah_z,
  input  acc_t          ah_n,
  input  fx_t           bx_r,
  input  fx_t           bx_z,
  input  fx_t           bx_n,
  input  fx_t           bh_r,
  input  fx_t           bh_z,
  input  fx_t           bh_n,
  input  fx_t           h_old,
  output logic          out_vld,
  output logic [IW-1:0] out_idx,
  output fx_t           h_new
);
  localparam int NST = 6;

  logic [NST-1:0] vld;
  logic [IW-1:0]  idx [NST];

  // stage 1: bias folding of both paths
  fx_t s1_pxr, s1_phr, s1_pxz, s1_phz, s1_pxn, s1_phn, s1_h;
  // stage 2: gate sums
  fx_t s2_sr, s2_sz, s2_pxn, s2_phn, s2_h;
  // stage 3: activations
  fx_t s3_r, s3_z, s3_pxn, s3_phn, s3_h;
  // stage 4: candidate multiply-add
  fx_t s4_c, s4_z, s4_h;
  // stage 5: tanh
  fx_t s5_n, s5_z, s5_h;

  always_ff @(posedge clk) begin
    if (rst) vld <= '0;
    else     vld <= {vld[NST-2:0], in_vld};
  end

  always_ff @(posedge clk) begin
    idx[0] <= in_idx;
    for (int k = 1; k < NST; k++) idx[k] <= idx[k-1];
  end

  always_ff @(posedge clk) begin
    s1_pxr <= fold_bias(ax_r, bx_r);
    s1_phr <= fold_bias(ah_r, bh_r);
    s1_pxz <= fold_bias(ax_z, bx_z);
    s1_phz <= fold_bias(ah_z, bh_z);
    s1_pxn <= fold_bias(ax_n, bx_n);
    s1_phn <= fold_bias(ah_n, bh_n);
    s1_h   <= h_old;

    s2_sr  <= sat_fx(acc_t'(s1_pxr) + acc_t'(s1_phr));
    s2_sz  <= sat_fx(acc_t'(s1_pxz) + acc_t'(s1_phz));
    s2_pxn <= s1_pxn;
    s2_phn <= s1_phn;
    s2_h   <= s1_h;

    s3_r   <= hsig(s2_sr);
    s3_z   <= hsig(s2_sz);
    s3_pxn <= s2_pxn;
    s3_phn <= s2_phn;
    s3_h   <= s2_h;

    s4_c   <= sat_fx(mul_rnd(s3_r, s3_phn) + acc_t'(s3_pxn));
    s4_z   <= s3_z;
    s4_h   <= s3_h;

    s5_n   <= htanh(s4_c);
    s5_z   <= s4_z;
    s5_h   <= s4_h;

    h_new  <= sat_fx(acc_t'(s5_n) +
                     rnd_sh((acc_t'(s5_h) - acc_t'(s5_n)) * acc_t'(s5_z)));
  end

  assign out_vld = vld[NST-1];
  assign out_idx = idx[NST-1];

  AST_PIPE_LATENCY: assert property (@(posedge clk) disable iff (rst)
    in_vld |-> ##(NST) out_vld); // R6
endmodule

// File: rtl/gru_cell.sv
module gru_cell
  import gru_pkg::*;
#(
  parameter int IN_DIM  = 4,
  parameter int HID     = 4,
  parameter int SEQ_LEN = 3,
  parameter int LANES   = 2,
  localparam int COLS   = 3 * HID,
  localparam int CPL    = COLS / LANES,
  localparam int MAXR   = (IN_DIM > HID) ? IN_DIM : HID,
  localparam int RW     = (MAXR > 1) ? $clog2(MAXR) : 1,
  localparam int CW     = $clog2(COLS),
  localparam int CGW    = (CPL > 1) ? $clog2(CPL) : 1,
  localparam int IW     = (HID > 1) ? $clog2(HID) : 1,
  localparam int TW     = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              seq_start,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [RW-1:0]     cfg_row,
  input  logic [CW-1:0]     cfg_col,
  input  logic [15:0]       cfg_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic signed [15:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic signed [15:0] out_data,
  output logic              out_last
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_MACX, ST_MACH, ST_FLUSH, ST_GATE, ST_DRAIN, ST_EMIT
  } state_t;

  state_t          state;
  fx_t             xbuf [IN_DIM];
  fx_t             hst  [HID];
  acc_t            accx [COLS];
  acc_t            acch [COLS];
  fx_t             bx   [COLS];
  fx_t             bh   [COLS];
  logic [RW-1:0]   cnt_row;
  logic [CGW-1:0]  cnt_cg;
  logic [TW-1:0]   tstep;
  logic [IW-1:0]   gidx;
  logic [IW-1:0]   oidx;

  logic            p_vld;
  logic            p_ph;
  logic [CGW-1:0]  p_cg;
  fx_t             p_op;

  logic [LANES-1:0][DW-1:0] rd_x;
  logic [LANES-1:0][DW-1:0] rd_h;

  logic            g_vld;
  logic [IW-1:0]   g_idx;
  fx_t             g_h;

  logic            in_fire;
  logic            acc_clr;
  logic            last_row;
  logic            last_cg;
  logic            final_step;

  // parameter write decode
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < COLS; c++) begin
        bx[c] <= '0;
        bh[c] <= '0;
      end
    end else if (cfg_we) begin
      if (cfg_sel == SEL_BX) bx[cfg_col] <= fx_t'(cfg_data);
      if (cfg_sel == SEL_BH) bh[cfg_col] <= fx_t'(cfg_data);
    end
  end

  gru_wstore #(.ROWS(IN_DIM), .COLS(COLS), .LANES(LANES), .DW(DW),
               .RW(RW), .CW(CW), .CGW(CGW)) u_wx (
    .clk   (clk),
    .we    (cfg_we && cfg_sel == SEL_WX),
    .wrow  (cfg_row),
    .wcol  (cfg_col),
    .wdata (cfg_data),
    .rrow  (cnt_row),
    .rcg   (cnt_cg),
    .rdata (rd_x)
  );

  gru_wstore #(.ROWS(HID), .COLS(COLS), .LANES(LANES), .DW(DW),
               .RW(RW), .CW(CW), .CGW(CGW)) u_wh (
    .clk   (clk),
    .we    (cfg_we && cfg_sel == SEL_WH),
    .wrow  (cfg_row),
    .wcol  (cfg_col),
    .wdata (cfg_data),
    .rrow  (cnt_row),
    .rcg   (cnt_cg),
    .rdata (rd_h)
  );

  always_comb begin
    in_ready   = (state == ST_LOAD);
    in_fire    = in_valid && in_ready && !seq_start;
    last_cg    = (cnt_cg == CGW'(CPL-1));
    last_row   = (state == ST_MACX) ? (cnt_row == RW'(IN_DIM-1))
                                    : (cnt_row == RW'(HID-1));
    acc_clr    = in_fire && (cnt_row == RW'(IN_DIM-1));
    final_step = (tstep == TW'(SEQ_LEN-1));
  end

  // operand tag travels alongside the registered weight read
  always_ff @(posedge clk) begin
    if (rst) p_vld <= 1'b0;
    else     p_vld <= (state == ST_MACX || state == ST_MACH) && !seq_start;
    p_ph <= (state == ST_MACH);
    p_cg <= cnt_cg;
    p_op <= (state == ST_MACH) ? hst[cnt_row] : xbuf[cnt_row];
  end

  // lane-parallel multiply-accumulate into the two product sets
  always_ff @(posedge clk) begin
    if (acc_clr) begin
      for (int c = 0; c < COLS; c++) begin
        accx[c] <= '0;
        acch[c] <= '0;
      end
    end else if (p_vld) begin
      for (int l = 0; l < LANES; l++) begin
        if (!p_ph)
          accx[int'(p_cg)*LANES + l] <= accx[int'(p_cg)*LANES + l] +
                                        acc_t'(fx_t'(rd_x[l])) * acc_t'(p_op);
        else
          acch[int'(p_cg)*LANES + l] <= acch[int'(p_cg)*LANES + l] +
                                        acc_t'(fx_t'(rd_h[l])) * acc_t'(p_op);
      end
    end
  end

  gru_gate_pipe #(.IW(IW)) u_gate (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (state == ST_GATE),
    .in_idx  (gidx),
    .ax_r    (accx[int'(gidx)]),
    .ax_z    (accx[int'(gidx) + HID]),
    .ax_n    (accx[int'(gidx) + 2*HID]),
    .ah_r    (acch[int'(gidx)]),
    .ah_z    (acch[int'(gidx) + HID]),
    .ah_n    (acch[int'(gidx) + 2*HID]),
    .bx_r    (bx[int'(gidx)]),
    .bx_z    (bx[int'(gidx) + HID]),
    .bx_n    (bx[int'(gidx) + 2*HID]),
    .bh_r    (bh[int'(gidx)]),
    .bh_z    (bh[int'(gidx) + HID]),
    .bh_n    (bh[int'(gidx) + 2*HID]),
    .h_old   (hst[gidx]),
    .out_vld (g_vld),
    .out_idx (g_idx),
    .h_new   (g_h)
  );

  // sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt_row   <= '0;
      cnt_cg    <= '0;
      tstep     <= '0;
      gidx      <= '0;
      oidx      <= '0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_data  <= '0;
      for (int i = 0; i < HID; i++) hst[i] <= '0;
    end else if (seq_start) begin
      state     <= ST_LOAD;
      cnt_row   <= '0;
      cnt_cg    <= '0;
      tstep     <= '0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      for (int i = 0; i < HID; i++) hst[i] <= '0;
    end else begin
      if (g_vld && (state == ST_GATE || state == ST_DRAIN)) hst[g_idx] <= g_h;
      case (state)
        ST_IDLE: ;
        ST_LOAD: begin
          if (in_fire) begin
            xbuf[cnt_row] <= in_data;
            if (cnt_row == RW'(IN_DIM-1)) begin
              cnt_row <= '0;
              cnt_cg  <= '0;
              state   <= ST_MACX;
            end else begin
              cnt_row <= cnt_row + 1'b1;
            end
          end
        end
        ST_MACX, ST_MACH: begin
          if (last_cg) begin
            cnt_cg <= '0;
            if (last_row) begin
              cnt_row <= '0;
              state   <= (state == ST_MACX) ? ST_MACH : ST_FLUSH;
            end else begin
              cnt_row <= cnt_row + 1'b1;
            end
          end else begin
            cnt_cg <= cnt_cg + 1'b1;
          end
        end
        ST_FLUSH: begin
          gidx  <= '0;
          state <= ST_GATE;
        end
        ST_GATE: begin
          if (gidx == IW'(HID-1)) state <= ST_DRAIN;
          else                    gidx  <= gidx + 1'b1;
        end
        ST_DRAIN: begin
          if (g_vld && g_idx == IW'(HID-1)) begin
            oidx  <= '0;
            state <= ST_EMIT;
          end
        end
        ST_EMIT: begin
          if (!out_valid) begin
            out_valid <= 1'b1;
            out_data  <= hst[oidx];
            out_last  <= final_step && (oidx == IW'(HID-1));
          end else if (out_ready) begin
            if (oidx == IW'(HID-1)) begin
              out_valid <= 1'b0;
              out_last  <= 1'b0;
              if (final_step) begin
                state <= ST_IDLE;
              end else begin
                tstep   <= tstep + 1'b1;
                cnt_row <= '0;
                state   <= ST_LOAD;
              end
            end else begin
              oidx     <= oidx + 1'b1;
              out_data <= hst[oidx + 1'b1];
              out_last <= final_step && ((oidx + 1'b1) == IW'(HID-1));
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  logic h_nonzero;
  always_comb begin
    h_nonzero = 1'b0;
    for (int i = 0; i < HID; i++) h_nonzero = h_nonzero | (|hst[i]);
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready && !seq_start |=>
      out_valid && $stable(out_data) && $stable(out_last)); // R8
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    seq_start |=> !h_nonzero && !out_valid); // R9
  AST_IO_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> !out_valid); // R2
  AST_LAST_ENDS_SEQ: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && out_last && !seq_start |=> !out_valid && !in_ready); // R7
endmodule

// File: tb/gru_cell_tb.sv
`timescale 1ns/1ps
module gru_cell_tb;
  localparam int IN_DIM  = 4;
  localparam int HID     = 4;
  localparam int SEQ_LEN = 3;
  localparam int LANES   = 2;
  localparam int COLS    = 3 * HID;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst, seq_start, cfg_we, in_valid, out_ready;
  logic [1:0]  cfg_sel;
  logic [1:0]  cfg_row;
  logic [3:0]  cfg_col;
  logic [15:0] cfg_data;
  logic signed [15:0] in_data;
  logic        in_ready, out_valid, out_last;
  logic signed [15:0] out_data;

  gru_cell #(.IN_DIM(IN_DIM), .HID(HID), .SEQ_LEN(SEQ_LEN), .LANES(LANES)) u_dut (
    .clk(clk), .rst(rst), .seq_start(seq_start), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_row(cfg_row), .cfg_col(cfg_col), .cfg_data(cfg_data),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  longint wx [IN_DIM][COLS];
  longint wh [HID][COLS];
  longint bxv [COLS];
  longint bhv [COLS];
  longint href [HID];
  longint xv [SEQ_LEN][IN_DIM];

  function automatic longint sat(input longint v);
    if (v > 32767)  return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction
  function automatic longint rnd(input longint v);
    return (v + 2048) >>> 12;
  endfunction
  function automatic longint sig(input longint v);
    longint t;
    t = (v >>> 2) + 2048;
    if (t < 0) return 0;
    if (t > 4096) return 4096;
    return t;
  endfunction
  function automatic longint tnh(input longint v);
    if (v > 4096)  return 4096;
    if (v < -4096) return -4096;
    return v;
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic ref_step(input int t);
    longint px [COLS];
    longint ph [COLS];
    longint hn [HID];
    for (int g = 0; g < COLS; g++) begin
      longint sx = 0;
      longint sh = 0;
      for (int j = 0; j < IN_DIM; j++) sx += wx[j][g] * xv[t][j];
      for (int k = 0; k < HID; k++)    sh += wh[k][g] * href[k];
      px[g] = sat(rnd(sx + bxv[g] * 4096));
      ph[g] = sat(rnd(sh + bhv[g] * 4096));
    end
    for (int i = 0; i < HID; i++) begin
      longint r, z, n;
      r = sig(sat(px[i] + ph[i]));
      z = sig(sat(px[HID+i] + ph[HID+i]));
      n = tnh(sat(rnd(r * ph[2*HID+i]) + px[2*HID+i]));
      hn[i] = sat(n + rnd((href[i] - n) * z));
    end
    for (int i = 0; i < HID; i++) href[i] = hn[i];
  endtask

  task automatic cfg_write(input logic [1:0] sel, input int row, input int col,
                           input longint val);
    @(negedge clk);
    cfg_we   = 1'b1;
    cfg_sel  = sel;
    cfg_row  = 2'(row);
    cfg_col  = 4'(col);
    cfg_data = 16'(val);
    @(negedge clk);
    cfg_we   = 1'b0;
  endtask

  task automatic load_params(input int seed, input int scale, input int xs);
    for (int g = 0; g < COLS; g++) begin
      for (int j = 0; j < IN_DIM; j++) begin
        wx[j][g] = longint'(((j*7 + g*5 + seed*3) % 17) - 8) * scale;
        cfg_write(2'd0, j, g, wx[j][g]);
      end
      for (int k = 0; k < HID; k++) begin
        wh[k][g] = longint'(((k*3 + g*11 + seed*5) % 13) - 6) * scale;
        cfg_write(2'd1, k, g, wh[k][g]);
      end
      bxv[g] = longint'(((g*3 + seed) % 9) - 4) * (scale / 2);
      bhv[g] = longint'(((g*5 + seed*2) % 7) - 3) * (scale / 2);
      cfg_write(2'd2, 0, g, bxv[g]);
      cfg_write(2'd3, 0, g, bhv[g]);
    end
    for (int t = 0; t < SEQ_LEN; t++)
      for (int j = 0; j < IN_DIM; j++)
        xv[t][j] = longint'(((t*11 + j*5 + seed*7) % 15) - 7) * 500 * xs;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    seq_start = 1'b1;
    @(negedge clk);
    seq_start = 1'b0;
  endtask

  task automatic send_vec(input int t, input int count, input bit gaps);
    for (int j = 0; j < count; j++) begin
      @(negedge clk);
      if (gaps && (j % 2 == 1)) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_data  = 16'(xv[t][j]);
      while (!in_ready) @(negedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic recv_step(input int t, input bit bp, input string tag);
    for (int i = 0; i < HID; i++) begin
      bit   held_ok = 1'b0;
      logic signed [15:0] held = '0;
      forever begin
        @(negedge clk);
        if (held_ok && out_valid) check("R8 held data", out_data, held);
        held_ok  = 1'b0;
        out_ready = bp ? ((cyc % 3) != 1) : 1'b1;
        if (out_valid && !out_ready) begin
          held    = out_data;
          held_ok = 1'b1;
        end
        if (out_valid && out_ready) begin
          check(tag, out_data, href[i]);
          check("R7 out_last", out_last, (i == HID-1 && t == SEQ_LEN-1));
          check("R2 in_ready low while emitting", in_ready, 0);
          break;
        end
      end
    end
  endtask

  task automatic run_seq(input bit bp, input bit gaps, input string tag);
    pulse_start();
    for (int i = 0; i < HID; i++) href[i] = 0;
    for (int t = 0; t < SEQ_LEN; t++) begin
      send_vec(t, IN_DIM, gaps);
      ref_step(t);
      recv_step(t, bp, tag);
    end
    repeat (4) @(negedge clk);
    check("R7 idle in_ready after final step", in_ready, 0);
    check("R7 idle out_valid after final step", out_valid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R7 watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; seq_start = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_row = '0;
    cfg_col = '0; cfg_data = '0; in_valid = 1'b0; in_data = '0; out_ready = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R2 reset in_ready", in_ready, 0);
    check("R2 reset out_valid", out_valid, 0);

    // R1 R3 R4 R5 R6: moderate values, several patterns
    load_params(0, 300, 1);
    run_seq(1'b0, 1'b0, "R1 R3 R4 R5 R6 seed0 hidden");
    load_params(1, 300, 1);
    run_seq(1'b1, 1'b0, "R1 R3 R4 R5 R6 R8 seed1 backpressure");
    load_params(2, 450, 1);
    run_seq(1'b1, 1'b1, "R2 R3 R6 seed2 gaps");
    // R9: second run with same weights restarts from a zero hidden state
    run_seq(1'b0, 1'b1, "R9 rerun from zero state");

    // R10: large weights and inputs force clamping
    load_params(3, 2500, 4);
    run_seq(1'b0, 1'b0, "R10 saturation");

    // R9: abort in the middle of a vector with state left over
    load_params(4, 350, 1);
    pulse_start();
    for (int i = 0; i < HID; i++) href[i] = 0;
    send_vec(0, IN_DIM, 1'b0);
    ref_step(0);
    recv_step(0, 1'b0, "R9 pre-abort step");
    send_vec(1, 2, 1'b0);
    run_seq(1'b1, 1'b0, "R9 after abort");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule